// File: doc/BRIEF.md
# Dual Comparator Output Control

This block is the digital side of a pair of analog comparators. Each comparator has an 8-bit control register. The fields are: power-on, a two-bit selector for the inverting-input source, a selector for the non-inverting source (internal reference or external input), an output-enable for the shared pin, a polarity bit and a speed bit. The analog front ends are outside the block. The block drives their selectors, speed and power-on as plain outputs and receives each comparator's raw decision as a digital input. A raw value of 1 means the inverting input is below the non-inverting one.

The block gates each raw decision with the comparator's power-on bit and applies polarity. The resulting value feeds the shared output pin combinationally, without passing through a register. A copy of it is registered only on the instruction-cycle strobe. The registered copies appear in bit 6 of each control register readback and together in a combined status vector, so one read returns both. One pin is shared by both comparators. A fixed priority picks what the pin carries: the higher-numbered comparator with its output-enable set, or the port data latch when no output-enable is set. The block also produces the pin's driver enable.

Top module: `dual_cmp_ctrl`

## Requirements
- R1: After reset each control readback is 8'h08: only the speed bit (bit 3) is set. The combined status vector is 0.
- R2: Writing control register i (select wr_sel=i) stores the power-on bit (bit 7), output-enable (bit 5), polarity (bit 4), speed (bit 3), reference select (bit 2) and channel (bits 1:0). The data on bit 6 is ignored, because bit 6 always reads back the registered result.
- R3: A comparator whose power-on bit is clear yields a result of 0, both on the live pin path and in the registered copy, whatever its raw input and polarity.
- R4: With power-on set, the result equals the raw input when polarity is 0 and its inverse when polarity is 1.
- R5: The registered result of each comparator takes its new value only on a clock edge where cyc_strobe is high. Otherwise it holds.
- R6: Bit i of stat_both equals bit 6 of control readback i.
- R7: Pin value priority. If comparator 1's output-enable is set, pin_out is comparator 1's live result. Otherwise, if comparator 0's output-enable is set, pin_out is comparator 0's live result. Otherwise pin_out is port_latch. This holds whether or not the selected comparator is powered.
- R8: pin_oe is 1 only when pin_tris is 0. If the selected comparator's output-enable is set, pin_oe also needs that comparator to be powered. With no output-enable set, pin_oe is the inverse of pin_tris.
- R9: pin_out follows a change on the raw input in the same cycle, without waiting for a strobe.
- R10: ana_en, chan_sel, ref_sel and speed_sel carry the power-on, channel, reference and speed fields of each register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cyc_strobe | input | 1 | Instruction-cycle strobe that updates the registered results |
| wr_en | input | 1 | Control register write enable |
| wr_sel | input | 1 | Index of the control register to write |
| wr_data | input | 8 | Write data |
| raw_res | input | 2 | Raw decision per comparator (1 = inverting input below non-inverting) |
| port_latch | input | 1 | Port data latch value for the shared pin |
| pin_tris | input | 1 | Tristate bit of the shared pin (1 = input) |
| ctrl_rd | output | 2x8 | Control readback per comparator, bit 6 = registered result |
| stat_both | output | 2 | Both registered results in one vector |
| ana_en | output | 2 | Power-on per comparator |
| chan_sel | output | 2x2 | Inverting-input mux select per comparator |
| ref_sel | output | 2 | Non-inverting source select per comparator |
| speed_sel | output | 2 | Speed select per comparator (1 = normal) |
| pin_out | output | 1 | Shared pin value |
| pin_oe | output | 1 | Shared pin driver enable |

## Verification
The assertions check on every cycle that the registered results hold between strobes, and that a strobe captures the gated, polarity-adjusted raw value. They also check the pin's priority choice, and that the driver never turns on while the tristate bit is set. Reset values, write masking of bit 6, and the same-cycle response of the pin to a raw change can only be shown by the bench's scenarios. The same holds for the driver staying off when an output-enabled comparator is unpowered. The bench's reference model is compared against every output on every clock across these scenarios.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
  localparam int REG_W   = 8;
  localparam int CH_W    = 2;
  localparam int B_EN    = 7;
  localparam int B_OUT   = 6;
  localparam int B_OE    = 5;
  localparam int B_POL   = 4;
  localparam int B_SPD   = 3;
  localparam int B_REF   = 2;

  typedef struct packed {
    logic            en;
    logic            oe;
    logic            pol;
    logic            spd;
    logic            rsel;
    logic [CH_W-1:0] ch;
  } cmp_cfg_t;

  localparam cmp_cfg_t CFG_RST = '{en: 1'b0, oe: 1'b0, pol: 1'b0, spd: 1'b1,
                                   rsel: 1'b0, ch: '0};

  function automatic cmp_cfg_t unpack_cfg(input logic [REG_W-1:0] d);
    cmp_cfg_t c;
    c.en   = d[B_EN];
    c.oe   = d[B_OE];
    c.pol  = d[B_POL];
    c.spd  = d[B_SPD];
    c.rsel = d[B_REF];
    c.ch   = d[CH_W-1:0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_rd(input cmp_cfg_t c, input logic q);
    logic [REG_W-1:0] d;
    d             = '0;
    d[B_EN]       = c.en;
    d[B_OUT]      = q;
    d[B_OE]       = c.oe;
    d[B_POL]      = c.pol;
    d[B_SPD]      = c.spd;
    d[B_REF]      = c.rsel;
    d[CH_W-1:0]   = c.ch;
    return d;
  endfunction
endpackage

// File: rtl/dcmp_cfg_reg.sv
module dcmp_cfg_reg
  import dcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wr_data,
  output cmp_cfg_t         cfg
);
  cmp_cfg_t cfg_d;

  // Bit 6 of the write data is dropped by unpack_cfg.
  always_comb begin
    cfg_d = cfg;
    if (wr_hit) cfg_d = unpack_cfg(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= CFG_RST;
    else if (wr_hit) cfg <= cfg_d;
  end
endmodule

// File: rtl/dcmp_result.sv
module dcmp_result
  import dcmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     strobe,
  input  cmp_cfg_t cfg,
  input  logic     raw,
  output logic     live,
  output logic     held
);
  logic held_d;

  always_comb begin
    live   = cfg.en & (raw ^ cfg.pol);
    held_d = held;
    if (strobe) held_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held <= 1'b0;
    else if (strobe) held <= held_d;
  end
endmodule

// File: rtl/dcmp_pin_route.sv
module dcmp_pin_route #(
  parameter int NCMP = 2
) (
  input  logic [NCMP-1:0] oe,
  input  logic [NCMP-1:0] en,
  input  logic [NCMP-1:0] live,
  input  logic            port_latch,
  input  logic            pin_tris,
  output logic            pin_out,
  output logic            pin_oe
);
  always_comb begin
    logic drv_ok;
    pin_out = port_latch;
    drv_ok  = 1'b1;
    // Ascending scan: the highest-numbered enabled comparator wins.
    for (int i = 0; i < NCMP; i++) begin
      if (oe[i]) begin
        pin_out = live[i];
        drv_ok  = en[i];
      end
    end
    pin_oe = drv_ok & ~pin_tris;
  end
endmodule

// File: rtl/dual_cmp_ctrl.sv
module dual_cmp_ctrl
  import dcmp_pkg::*;
#(
  parameter int NCMP  = 2,
  localparam int SEL_W = (NCMP > 1) ? $clog2(NCMP) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cyc_strobe,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [REG_W-1:0]           wr_data,
  input  logic [NCMP-1:0]            raw_res,
  input  logic                       port_latch,
  input  logic                       pin_tris,
  output logic [NCMP-1:0][REG_W-1:0] ctrl_rd,
  output logic [NCMP-1:0]            stat_both,
  output logic [NCMP-1:0]            ana_en,
  output logic [NCMP-1:0][CH_W-1:0]  chan_sel,
  output logic [NCMP-1:0]            ref_sel,
  output logic [NCMP-1:0]            speed_sel,
  output logic                       pin_out,
  output logic                       pin_oe
);
  logic [1:0]      rst_pipe;
  logic            rst_int_n;
  logic [NCMP-1:0] live;
  logic [NCMP-1:0] oe_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    cmp_cfg_t cfg;
    logic     held;

    dcmp_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_hit  (wr_en && (wr_sel == SEL_W'(i))),
      .wr_data (wr_data),
      .cfg     (cfg)
    );

    dcmp_result u_res (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .strobe (cyc_strobe),
      .cfg    (cfg),
      .raw    (raw_res[i]),
      .live   (live[i]),
      .held   (held)
    );

    assign ctrl_rd[i]   = pack_rd(cfg, held);
    assign stat_both[i] = held;
    assign ana_en[i]    = cfg.en;
    assign chan_sel[i]  = cfg.ch;
    assign ref_sel[i]   = cfg.rsel;
    assign speed_sel[i] = cfg.spd;
    assign oe_v[i]      = cfg.oe;
  end

  dcmp_pin_route #(.NCMP(NCMP)) u_pin (
    .oe         (oe_v),
    .en         (ana_en),
    .live       (live),
    .port_latch (port_latch),
    .pin_tris   (pin_tris),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
  );
endmodule

// File: rtl/dcmp_chk.sv
module dcmp_chk
  import dcmp_pkg::*;
#(
  parameter int NCMP = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cyc_strobe,
  input logic [NCMP-1:0]            raw_res,
  input logic                       port_latch,
  input logic                       pin_tris,
  input logic [NCMP-1:0][REG_W-1:0] ctrl_rd,
  input logic [NCMP-1:0]            stat_both,
  input logic                       pin_out,
  input logic                       pin_oe
);
  logic [NCMP-1:0] oe_seen;
  logic [NCMP-1:0] exp_live;
  for (genvar i = 0; i < NCMP; i++) begin : g_v
    assign oe_seen[i]  = ctrl_rd[i][B_OE];
    assign exp_live[i] = ctrl_rd[i][B_EN] & (raw_res[i] ^ ctrl_rd[i][B_POL]);
  end

  // R5
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_strobe |=> $stable(stat_both));

  for (genvar i = 0; i < NCMP; i++) begin : g_lat
    // R3 R4
    strobe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_strobe |=> stat_both[i] == $past(exp_live[i]));
  end

  // R7
  pin_top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_seen[NCMP-1] |-> pin_out == exp_live[NCMP-1]);

  // R7
  pin_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_seen == '0) |-> pin_out == port_latch);

  // R8
  pin_tris_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_tris |-> !pin_oe);
endmodule

bind dual_cmp_ctrl dcmp_chk #(.NCMP(NCMP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_strobe (cyc_strobe),
  .raw_res    (raw_res),
  .port_latch (port_latch),
  .pin_tris   (pin_tris),
  .ctrl_rd    (ctrl_rd),
  .stat_both  (stat_both),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe)
);

// File: tb/dual_cmp_ctrl_test.sv
`timescale 1ns/1ps
module dual_cmp_ctrl_test;
  logic            clk = 1'b0;
  logic            rst_n;
  logic            cyc_strobe, wr_en, wr_sel, port_latch, pin_tris;
  logic [7:0]      wr_data;
  logic [1:0]      raw_res;
  logic [1:0][7:0] ctrl_rd;
  logic [1:0]      stat_both, ana_en, ref_sel, speed_sel;
  logic [1:0][1:0] chan_sel;
  logic            pin_out, pin_oe;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  dual_cmp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .raw_res(raw_res),
    .port_latch(port_latch), .pin_tris(pin_tris), .ctrl_rd(ctrl_rd),
    .stat_both(stat_both), .ana_en(ana_en), .chan_sel(chan_sel),
    .ref_sel(ref_sel), .speed_sel(speed_sel), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Reference model state: stored control bytes (bit 6 unused) and held results.
  logic [7:0] m_reg [2];
  logic       m_q   [2];

  function automatic logic m_live(int i);
    if (m_reg[i][7] == 1'b0) return 1'b0;
    return m_reg[i][4] ? ~raw_res[i] : raw_res[i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_reg[i] <= 8'h08;
        m_q[i]   <= 1'b0;
      end
    end else begin
      if (wr_en) m_reg[wr_sel] <= wr_data & 8'hBF;
      if (cyc_strobe)
        for (int i = 0; i < 2; i++) m_q[i] <= m_live(i);
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (cmp_on) begin
      #1;
      for (int i = 0; i < 2; i++) begin
        logic [7:0] exp_rd;
        exp_rd = m_reg[i];
        exp_rd[6] = m_q[i];
        chk("R2 readback", ctrl_rd[i], exp_rd);
        chk("R6 status", {7'd0, stat_both[i]}, {7'd0, m_q[i]});
        chk("R10 drive", {2'd0, ana_en[i], chan_sel[i], ref_sel[i], speed_sel[i]},
            {2'd0, m_reg[i][7], m_reg[i][1:0], m_reg[i][2], m_reg[i][3]});
      end
      begin
        logic ep, eo;
        if (m_reg[1][5]) begin
          ep = m_live(1); eo = m_reg[1][7] & ~pin_tris;
        end else if (m_reg[0][5]) begin
          ep = m_live(0); eo = m_reg[0][7] & ~pin_tris;
        end else begin
          ep = port_latch; eo = ~pin_tris;
        end
        chk("R7 pin value", {7'd0, pin_out}, {7'd0, ep});
        chk("R8 pin drive", {7'd0, pin_oe}, {7'd0, eo});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic s, logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    cyc_strobe = 1'b1;
    step();
    cyc_strobe = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cyc_strobe = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    raw_res = 2'b00; port_latch = 0; pin_tris = 1;
    repeat (3) step();
    cmp_on = 1;
    rst_n = 1'b1;
    repeat (4) step();
    // R1 reset state
    chk("R1 ctrl0", ctrl_rd[0], 8'h08);
    chk("R1 ctrl1", ctrl_rd[1], 8'h08);
    chk("R1 status", {6'd0, stat_both}, 8'h00);

    // R2 bit 6 ignored on write
    wr(1'b0, 8'hFF);
    chk("R2 bit6 masked", ctrl_rd[0], 8'hBF);
    wr(1'b0, 8'h00);

    // R3 disabled result stays 0
    raw_res = 2'b11;
    wr(1'b0, 8'h10);
    strobe();
    chk("R3 disabled held", {7'd0, stat_both[0]}, 8'h00);

    // R4 polarity
    wr(1'b0, 8'h80);
    strobe();
    chk("R4 pol0", {7'd0, stat_both[0]}, 8'h01);
    wr(1'b0, 8'h90);
    strobe();
    chk("R4 pol1", {7'd0, stat_both[0]}, 8'h00);

    // R5 hold without strobe
    wr(1'b0, 8'h80);
    repeat (3) step();
    chk("R5 hold", {7'd0, stat_both[0]}, 8'h00);
    strobe();
    chk("R5 capture", {7'd0, stat_both[0]}, 8'h01);

    // R6 both at once
    wr(1'b1, 8'h88);
    raw_res = 2'b10;
    strobe();
    chk("R6 both", {6'd0, stat_both}, 8'h02);

    // R7 / R8 priority and drive
    pin_tris = 0; port_latch = 1;
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    chk("R7 latch path", {7'd0, pin_out}, 8'h01);
    wr(1'b0, 8'hA0);
    raw_res = 2'b01;
    step();
    chk("R7 cmp0 path", {7'd0, pin_out}, 8'h01);
    wr(1'b1, 8'h20);
    chk("R7 cmp1 wins", {7'd0, pin_out}, 8'h00);
    chk("R8 unpowered no drive", {7'd0, pin_oe}, 8'h00);
    wr(1'b1, 8'hA0);
    chk("R8 powered drive", {7'd0, pin_oe}, 8'h01);
    pin_tris = 1;
    step();
    chk("R8 tris blocks", {7'd0, pin_oe}, 8'h00);

    // R9 pin follows raw in the same cycle
    pin_tris = 0;
    raw_res = 2'b10;
    #0.5;
    chk("R9 live pin", {7'd0, pin_out}, 8'h01);
    raw_res = 2'b00;
    #0.5;
    chk("R9 live pin fall", {7'd0, pin_out}, 8'h00);

    // R10 selector fields
    wr(1'b1, 8'h86);
    chk("R10 chan", {6'd0, chan_sel[1]}, 8'h02);
    chk("R10 ref/speed", {6'd0, ref_sel[1], speed_sel[1]}, 8'h02);

    repeat (20) begin
      raw_res = raw_res + 2'd1;
      cyc_strobe = ~cyc_strobe;
      step();
    end
    cyc_strobe = 0;
    step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule